// File: doc/BRIEF.md
# Pipelined Vector Adder

This block is a fixed-function streaming datapath. For every work-item index from 0 up to a requested count minus one, it computes `sum[id] = opa[id] + opb[id]` in 32-bit wrapping integer arithmetic. An index generator sends one work-item per clock into a three-stage pipeline. The load stage reads both operand RAMs. The add stage forms the sum. The store stage writes the result RAM. In steady state three different work-items are in flight at once, so the block delivers one result per clock.

Each stage carries a valid bit beside the work-item index, so the store stage always writes the address that belongs to its sum. A host fills the operand RAMs through a write port while the block is idle. It starts a run with a one-cycle `start` and a count. It waits for the one-cycle `done` pulse and then reads results through a registered read port.

Top module: `vadd_top`

## Requirements
- R1: While `rst` is high, and after it until the first accepted start, `done` is low.
- R2: After a run with count N, result entry i holds `opa[i] + opb[i]` for every i < N, using the operand values present when the run was started.
- R3: Result entries at index N and above keep the values they held before the run.
- R4: For N ≥ 1, `done` is high in exactly one cycle, sampled after the (N+3)-th rising edge counted from the edge that accepted `start`. This follows from one work-item issued per clock in increasing order from 0, with three registered stages behind the issue point.
- R5: A run with count 0 writes no result entry and raises `done` after the first edge following the accepting edge.
- R6: `start` is ignored while a run is in progress. Neither the count nor the timing of `done` changes.
- R7: `done` lasts one cycle. A `start` held during that cycle is accepted on the next edge.
- R8: `host_rd_data` shows the result entry addressed by `host_rd_addr` one rising edge after the address is applied.
- R9: Sums wrap modulo 2^32. For example, 0xFFFFFFFF + 2 gives 1.
- R10: A count of 256 (the full index space, `count` encoded as 9'h100) processes every entry.
- R11: Host write port: `host_wr_sel` = 0 writes operand A and `host_wr_sel` = 1 writes operand B, at `host_wr_addr`, on an edge where `host_wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; sampled only while idle |
| count | input | 9 | Number of work-items, 0 to 256 |
| done | output | 1 | One-cycle pulse after the pipeline drains |
| host_wr_en | input | 1 | Operand write strobe |
| host_wr_sel | input | 1 | 0 selects operand A, 1 selects operand B |
| host_wr_addr | input | 8 | Operand write index |
| host_wr_data | input | 32 | Operand write value |
| host_rd_addr | input | 8 | Result read index |
| host_rd_data | output | 32 | Result read value, one cycle after address |

## Verification
Two cases are hard to reach from the ports. One is a `start` arriving mid-run with a different count. The other is a `start` presented in the very cycle `done` is high. The bench drives both: a second start with a smaller count four cycles into a 20-item run, and a start issued at the negative edge where `done` is observed. A behavioural timing model follows the completion pulse on every clock. A shorter run over entries already written by a longer run shows that nothing above the new count is disturbed.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
    parameter int DATA_W = 32;
    parameter int ID_W   = 8;
    localparam int DEPTH  = 1 << ID_W;
    localparam int CNT_W  = ID_W + 1;
    localparam int STAGES = 3;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // Work-item tag carried through the load stage
    typedef struct packed {
        logic vld;
        id_t  id;
    } tag_t;

    // Tag plus computed sum, carried into the store stage
    typedef struct packed {
        logic  vld;
        id_t   id;
        word_t sum;
    } res_t;

    function automatic word_t wrap_add(input word_t x, input word_t y);
        return x + y;
    endfunction
endpackage

// File: rtl/vadd_sram.sv
module vadd_sram #(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int N = 1 << AW;
    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/vadd_issue.sv
module vadd_issue
    import vadd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cnt_t count,
    input  logic pipe_empty,
    output tag_t issue_tag,
    output logic busy,
    output logic done
);
    logic running;
    cnt_t next_id;
    cnt_t limit;

    always_comb begin
        issue_tag.vld = running && (next_id < limit);
        issue_tag.id  = next_id[ID_W-1:0];
    end
    assign busy = running;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            next_id <= '0;
            limit   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!running) begin
                if (start) begin
                    running <= 1'b1;
                    limit   <= count;
                    next_id <= '0;
                end
            end else if (issue_tag.vld) begin
                next_id <= next_id + 1'b1;
            end else if (pipe_empty) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    // R7: completion pulse lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: issued indices step by one on consecutive cycles
    a_r4_issue_step: assert property (@(posedge clk) disable iff (rst)
        (issue_tag.vld && $past(issue_tag.vld)) |-> issue_tag.id == id_t'($past(issue_tag.id) + 1'b1));

    // R6: a start seen mid-run does not end or restart the run
    a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (running && start && issue_tag.vld) |=> running);
endmodule

// File: rtl/vadd_add_stage.sv
module vadd_add_stage
    import vadd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  tag_t  in_tag,
    input  word_t opa,
    input  word_t opb,
    output res_t  out_res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_res <= '0;
        end else begin
            out_res.vld <= in_tag.vld;
            out_res.id  <= in_tag.id;
            out_res.sum <= wrap_add(opa, opb);
        end
    end
endmodule

// File: rtl/vadd_top.sv
module vadd_top
    import vadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  count,
    output logic              done,
    input  logic              host_wr_en,
    input  logic              host_wr_sel,
    input  logic [ID_W-1:0]   host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [ID_W-1:0]   host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data
);
    tag_t              issue_tag;
    tag_t              ld_tag;
    res_t              st_res;
    logic              busy;
    logic              pipe_empty;
    logic [DATA_W-1:0] opnd [2];

    assign pipe_empty = !ld_tag.vld && !st_res.vld;

    vadd_issue u_issue (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .count      (count),
        .pipe_empty (pipe_empty),
        .issue_tag  (issue_tag),
        .busy       (busy),
        .done       (done)
    );

    // Operand RAMs: index 0 is operand A, index 1 is operand B
    for (genvar g = 0; g < 2; g++) begin : g_opram
        logic we_g;
        assign we_g = host_wr_en && (host_wr_sel == 1'(g));
        vadd_sram #(.W(DATA_W), .AW(ID_W)) u_ram (
            .clk   (clk),
            .we    (we_g),
            .waddr (host_wr_addr),
            .wdata (host_wr_data),
            .raddr (issue_tag.id),
            .rdata (opnd[g])
        );
    end

    // Load stage: tag aligned with the registered RAM outputs
    always_ff @(posedge clk) begin
        if (rst) ld_tag <= '0;
        else     ld_tag <= issue_tag;
    end

    vadd_add_stage u_add (
        .clk     (clk),
        .rst     (rst),
        .in_tag  (ld_tag),
        .opa     (opnd[0]),
        .opb     (opnd[1]),
        .out_res (st_res)
    );

    // Store stage
    vadd_sram #(.W(DATA_W), .AW(ID_W)) u_ans (
        .clk   (clk),
        .we    (st_res.vld),
        .waddr (st_res.id),
        .wdata (st_res.sum),
        .raddr (host_rd_addr),
        .rdata (host_rd_data)
    );

    // R3: stores happen only inside an active run
    a_r3_store_in_run: assert property (@(posedge clk) disable iff (rst)
        st_res.vld |-> busy);

    // R2: store addresses follow in increasing order
    a_r2_store_order: assert property (@(posedge clk) disable iff (rst)
        (st_res.vld && $past(st_res.vld)) |-> st_res.id == id_t'($past(st_res.id) + 1'b1));

    // R4: completion only once the pipeline holds no work-item
    a_r4_done_drained: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ld_tag.vld && !st_res.vld && !issue_tag.vld));

    // R5: an idle block stores nothing
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !st_res.vld);
endmodule

// File: tb/vadd_top_tb.sv
module vadd_top_tb;
    import vadd_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  start = 1'b0;
    cnt_t  count = '0;
    logic  done;
    logic  host_wr_en = 1'b0;
    logic  host_wr_sel = 1'b0;
    id_t   host_wr_addr = '0;
    word_t host_wr_data = '0;
    id_t   host_rd_addr = '0;
    word_t host_rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    vadd_top u_dut (
        .clk(clk), .rst(rst), .start(start), .count(count), .done(done),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
        .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Behavioural reference
    word_t m_a [DEPTH];
    word_t m_b [DEPTH];
    word_t m_ans [DEPTH];
    bit    m_known [DEPTH];
    bit    m_busy = 1'b0;
    bit    m_done = 1'b0;
    int    m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0;
            m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_left = (count == 0) ? 1 : int'(count) + STAGES;
                for (int i = 0; i < int'(count); i++) begin
                    m_ans[i]   = m_a[i] + m_b[i];
                    m_known[i] = 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison of the completion pulse (R1, R4, R5, R6, R7)
    always @(negedge clk) begin
        if (!finished) begin
            n_cmp++;
            if (done !== m_done) begin
                n_bad++;
                $display("FAIL R1/R4/R5/R6/R7 done at %0t: got %b expected %b", $time, done, m_done);
            end
        end
    end

    task automatic put(input bit sel, input int addr, input word_t d);
        @(negedge clk);
        host_wr_en   = 1'b1;
        host_wr_sel  = sel;
        host_wr_addr = id_t'(addr);
        host_wr_data = d;
        if (sel) m_b[addr] = d; else m_a[addr] = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        count = cnt_t'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    // R8: address applied at a negedge, data checked one edge later
    task automatic check_all(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            if (m_known[i]) begin
                @(negedge clk);
                host_rd_addr = id_t'(i);
                @(negedge clk);
                n_cmp++;
                if (host_rd_data !== m_ans[i]) begin
                    n_bad++;
                    $display("FAIL %s R8 entry %0d: got %h expected %h", tag, i, host_rd_data, m_ans[i]);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: done low in reset, compared every cycle
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2, R11: 8 items, A = 0..7, B = 7..0, all sums 7
        for (int i = 0; i < 8; i++) begin
            put(1'b0, i, word_t'(i));
            put(1'b1, i, word_t'(7 - i));
        end
        run(8);
        check_all("R2 example");

        // R5: count 0 writes nothing even after operands change
        for (int i = 0; i < 8; i++) put(1'b0, i, word_t'(100 + i));
        run(0);
        check_all("R5 zero count");

        // R3: long run, then a short run must leave upper entries alone
        for (int i = 0; i < 16; i++) begin
            put(1'b0, i, word_t'(i * 3));
            put(1'b1, i, word_t'(1000 + i));
        end
        run(16);
        for (int i = 0; i < 16; i++) put(1'b1, i, word_t'(5000 + i));
        run(5);
        check_all("R3 untouched above count");

        // R6: start with another count mid-run is ignored
        for (int i = 0; i < 20; i++) put(1'b0, i, word_t'(i * 11));
        @(negedge clk);
        count = cnt_t'(20);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        count = cnt_t'(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check_all("R6 start ignored");

        // R9: wrapping sums; R7: start issued during the done cycle
        put(1'b0, 0, 32'hFFFF_FFFF);
        put(1'b1, 0, 32'h0000_0002);
        put(1'b0, 1, 32'h8000_0000);
        put(1'b1, 1, 32'h8000_0000);
        @(negedge clk);
        count = cnt_t'(2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        count = cnt_t'(4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check_all("R9 wrap and R7 back-to-back");

        // R10: full index space with varied data
        for (int i = 0; i < DEPTH; i++) begin
            put(1'b0, i, $urandom());
            put(1'b1, i, $urandom());
        end
        run(DEPTH);
        check_all("R10 full range");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule